// File: doc/BRIEF.md
# Pointer-Chasing Page Table Walker

This block resolves a 14-bit virtual page number into a 13-bit physical page number for a translation cache that has missed. The virtual page number splits into a 5-bit section number (high bits) and a 9-bit page index (low bits). The walk reads a section entry from a fixed region of the current process table page. It then reads a page-map entry, and the result of that read is the physical page. Either level may hand the walk on through a shared-pointer table, or through an indirect pointer that re-enters another table of the same level. Each walk is therefore a pointer chase of variable length, not a fixed two-step lookup. The same walk serves user and executive contexts, because both use the same table layout. The caller supplies the process table page.

All table reads and status writes go through one word-wide memory port. A request on that port stays asserted until the memory acknowledges it, and read data arrives together with the acknowledge. When the status table is enabled, a successful walk marks the page-map page and then the final page as used. Each mark is a read-modify-write.

Top module: `page_walker`

## Requirements
- R1: After reset the walker is idle: `walkBusy`, `walkDone`, `walkFault` and `memReq` are all low.
- R2: A pointer word carries its kind in bits [35:33]. Code 1 (immediate) names its target page in bits [12:0], and the other bits are ignored. The section entry is read from word `SECT_OFF` + section of the `ptBase` page. The page-map entry is read from word = page index of the page-map page. The final immediate target is returned on `walkPpn` with a `walkDone` pulse.
- R3: Code 2 (shared) reads the shared-pointer word at `sptBase` + bits [17:0], and that word's bits [12:0] name the target. This works at both levels.
- R4: Code 3 (indirect) reads the shared-pointer word at `sptBase` + bits [17:0], whose bits [12:0] name another table of the same level. That table is then read at the word given by bits [26:18] of the indirect pointer.
- R5: Code 0 (invalid) at either level ends the walk with a `walkFault` pulse and `faultCause` = 1.
- R6: Codes 4 to 7 at either level end the walk with `walkFault` and `faultCause` = 2.
- R7: A walk may follow at most `MAX_HOPS` indirect pointers in total, across both levels. Meeting one more ends the walk with `walkFault` and `faultCause` = 3.
- R8: With `cstEn` high, a successful walk first reads the status word at `cstBase` + page-map page and writes it back with bit 0 set, then does the same for the status word at `cstBase` + final page. All other bits of each word are preserved.
- R9: No memory write happens while `cstEn` is low, and no memory write happens during a walk that faults.
- R10: Each accepted request produces exactly one one-cycle pulse, either `walkDone` or `walkFault`, after which the walker is idle. A memory request is held, with a stable address and direction, until `memAck` arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| walkReq | input | 1 | Start a walk (accepted when idle) |
| walkVpn | input | 14 | Virtual page number: section [13:9], page index [8:0] |
| ptBase | input | 13 | Physical page of the current process table |
| sptBase | input | 22 | Word address of the shared-pointer table |
| cstEn | input | 1 | Enable status-table marking, held stable during a walk |
| cstBase | input | 22 | Word address of the status table |
| walkBusy | output | 1 | A walk is in progress |
| walkDone | output | 1 | One-cycle pulse: translation succeeded |
| walkFault | output | 1 | One-cycle pulse: translation failed |
| walkPpn | output | 13 | Resulting physical page, valid with `walkDone` |
| faultCause | output | 2 | 1 invalid, 2 bad kind, 3 hop limit; valid with `walkFault` |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | Request is a write |
| memAddr | output | 22 | Word address |
| memWdata | output | 36 | Write data |
| memAck | input | 1 | Memory acknowledge, with read data |
| memRdata | input | 36 | Read data |

## Verification
The bench builds the walker with its default parameters: 36-bit words, a 5+9-bit virtual page number, 13-bit physical pages, an 8-hop indirect limit, and the section table at word 448 of the process table page. Because the hop limit is 8 and not a shrunken value, the bench can drive a chain that uses exactly all eight hops and a chain that needs a ninth. Section 31 with page index 511 reaches the last section slot (word 479) and the last page-map word. An all-ones final page and immediate words with set upper bits show that only the page field is taken.

// File: rtl/walk_pkg.sv
package walk_pkg;

  localparam logic [2:0] KIND_INVALID  = 3'd0;
  localparam logic [2:0] KIND_IMM      = 3'd1;
  localparam logic [2:0] KIND_SHARED   = 3'd2;
  localparam logic [2:0] KIND_INDIRECT = 3'd3;

  localparam logic [1:0] CAUSE_NONE    = 2'd0;
  localparam logic [1:0] CAUSE_INVALID = 2'd1;
  localparam logic [1:0] CAUSE_BADKIND = 2'd2;
  localparam logic [1:0] CAUSE_DEPTH   = 2'd3;

  typedef enum logic [1:0] {
    ADR_PTR,
    ADR_SPT,
    ADR_CMAP,
    ADR_CFIN
  } adrSel_e;

  typedef struct packed {
    logic    start;
    logic    capPtr;
    logic    advance;
    logic    useSpt;
    logic    redirect;
    logic    capCst;
    adrSel_e adrSel;
  } walkStrobe_t;

endpackage

// File: rtl/walk_datapath.sv
module walk_datapath
  import walk_pkg::*;
#(
  parameter int WORD_W   = 36,
  parameter int SEC_W    = 5,
  parameter int PG_W     = 9,
  parameter int PPN_W    = 13,
  parameter int MAX_HOPS = 8,
  parameter int SECT_OFF = 448,
  parameter int SPTI_W   = 18
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  walkStrobe_t               strobe,
  input  logic [SEC_W+PG_W-1:0]     walkVpn,
  input  logic [PPN_W-1:0]          ptBase,
  input  logic [PPN_W+PG_W-1:0]     sptBase,
  input  logic [PPN_W+PG_W-1:0]     cstBase,
  input  logic [WORD_W-1:0]         memRdata,
  output logic [PPN_W+PG_W-1:0]     memAddr,
  output logic [WORD_W-1:0]         memWdata,
  output logic [2:0]                ptrKind,
  output logic                      pageLevel,
  output logic                      hopLimit,
  output logic [PPN_W-1:0]          walkPpn
);
  localparam int VPN_W  = SEC_W + PG_W;
  localparam int ADDR_W = PPN_W + PG_W;
  localparam int HOP_W  = $clog2(MAX_HOPS + 1);
  localparam int IDX_LO = SPTI_W;

  logic [PG_W-1:0]   pageIdx;
  logic [PPN_W-1:0]  tblPage;
  logic [PG_W-1:0]   tblIdx;
  logic [2:0]        kindReg;
  logic [PG_W-1:0]   indIdx;
  logic [SPTI_W-1:0] lowField;
  logic [PPN_W-1:0]  mapPage;
  logic [PPN_W-1:0]  finalPpn;
  logic [HOP_W-1:0]  hopCnt;
  logic [WORD_W-1:0] cstWord;
  logic [PPN_W-1:0]  target;
  logic              unusedBits;

  assign unusedBits = ^memRdata[WORD_W-4:IDX_LO+PG_W];
  assign target = strobe.useSpt ? memRdata[PPN_W-1:0] : lowField[PPN_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageIdx   <= '0;
      tblPage   <= '0;
      tblIdx    <= '0;
      kindReg   <= '0;
      indIdx    <= '0;
      lowField  <= '0;
      mapPage   <= '0;
      finalPpn  <= '0;
      hopCnt    <= '0;
      cstWord   <= '0;
      pageLevel <= 1'b0;
    end else begin
      if (strobe.start) begin
        pageIdx   <= walkVpn[PG_W-1:0];
        tblPage   <= ptBase;
        tblIdx    <= PG_W'(SECT_OFF) + PG_W'(walkVpn[VPN_W-1:PG_W]);
        pageLevel <= 1'b0;
        hopCnt    <= '0;
      end
      if (strobe.capPtr) begin
        kindReg  <= memRdata[WORD_W-1 -: 3];
        indIdx   <= memRdata[IDX_LO +: PG_W];
        lowField <= memRdata[SPTI_W-1:0];
      end
      if (strobe.advance) begin
        if (!pageLevel) begin
          pageLevel <= 1'b1;
          tblPage   <= target;
          tblIdx    <= pageIdx;
          mapPage   <= target;
        end else begin
          finalPpn  <= target;
        end
      end
      if (strobe.redirect) begin
        tblPage <= memRdata[PPN_W-1:0];
        tblIdx  <= indIdx;
        hopCnt  <= hopCnt + 1'b1;
      end
      if (strobe.capCst) cstWord <= memRdata;
    end
  end

  always_comb begin
    case (strobe.adrSel)
      ADR_PTR:  memAddr = {tblPage, tblIdx};
      ADR_SPT:  memAddr = sptBase + ADDR_W'(lowField);
      ADR_CMAP: memAddr = cstBase + ADDR_W'(mapPage);
      default:  memAddr = cstBase + ADDR_W'(finalPpn);
    endcase
  end

  assign memWdata = cstWord | WORD_W'(1);
  assign ptrKind  = kindReg;
  assign hopLimit = (hopCnt == HOP_W'(MAX_HOPS));
  assign walkPpn  = finalPpn;

endmodule

// File: rtl/walk_control.sv
module walk_control
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        walkReq,
  input  logic        memAck,
  input  logic        cstEn,
  input  logic [2:0]  ptrKind,
  input  logic        pageLevel,
  input  logic        hopLimit,
  output walkStrobe_t strobe,
  output logic        memReq,
  output logic        memWe,
  output logic        walkBusy,
  output logic        walkDone,
  output logic        walkFault,
  output logic [1:0]  faultCause
);
  typedef enum logic [3:0] {
    S_IDLE, S_PTR, S_DEC, S_SPT, S_CRM, S_CWM, S_CRF, S_CWF, S_DONE, S_FAULT
  } state_e;

  state_e     state, stateNext, finishState, afterTarget;
  logic [1:0] causeNext;
  logic [1:0] causeReg;

  assign finishState = cstEn ? S_CRM : S_DONE;
  assign afterTarget = pageLevel ? finishState : S_PTR;

  always_comb begin
    strobe    = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    stateNext = state;
    causeNext = CAUSE_NONE;
    case (state)
      S_IDLE: if (walkReq) begin
        strobe.start = 1'b1;
        stateNext    = S_PTR;
      end
      S_PTR: begin
        memReq = 1'b1;
        strobe.adrSel = ADR_PTR;
        if (memAck) begin
          strobe.capPtr = 1'b1;
          stateNext     = S_DEC;
        end
      end
      S_DEC: begin
        case (ptrKind)
          KIND_INVALID: begin
            causeNext = CAUSE_INVALID;
            stateNext = S_FAULT;
          end
          KIND_IMM: begin
            strobe.advance = 1'b1;
            stateNext      = afterTarget;
          end
          KIND_SHARED: stateNext = S_SPT;
          KIND_INDIRECT: begin
            if (hopLimit) begin
              causeNext = CAUSE_DEPTH;
              stateNext = S_FAULT;
            end else begin
              stateNext = S_SPT;
            end
          end
          default: begin
            causeNext = CAUSE_BADKIND;
            stateNext = S_FAULT;
          end
        endcase
      end
      S_SPT: begin
        memReq = 1'b1;
        strobe.adrSel = ADR_SPT;
        if (memAck) begin
          if (ptrKind == KIND_INDIRECT) begin
            strobe.redirect = 1'b1;
            stateNext       = S_PTR;
          end else begin
            strobe.advance = 1'b1;
            strobe.useSpt  = 1'b1;
            stateNext      = afterTarget;
          end
        end
      end
      S_CRM: begin
        memReq = 1'b1;
        strobe.adrSel = ADR_CMAP;
        if (memAck) begin
          strobe.capCst = 1'b1;
          stateNext     = S_CWM;
        end
      end
      S_CWM: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        strobe.adrSel = ADR_CMAP;
        if (memAck) stateNext = S_CRF;
      end
      S_CRF: begin
        memReq = 1'b1;
        strobe.adrSel = ADR_CFIN;
        if (memAck) begin
          strobe.capCst = 1'b1;
          stateNext     = S_CWF;
        end
      end
      S_CWF: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        strobe.adrSel = ADR_CFIN;
        if (memAck) stateNext = S_DONE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      causeReg <= CAUSE_NONE;
    end else begin
      state <= stateNext;
      if (stateNext == S_FAULT) causeReg <= causeNext;
    end
  end

  assign walkBusy   = (state != S_IDLE);
  assign walkDone   = (state == S_DONE);
  assign walkFault  = (state == S_FAULT);
  assign faultCause = causeReg;

endmodule

// File: rtl/page_walker.sv
module page_walker
  import walk_pkg::*;
#(
  parameter int WORD_W   = 36,
  parameter int SEC_W    = 5,
  parameter int PG_W     = 9,
  parameter int PPN_W    = 13,
  parameter int MAX_HOPS = 8,
  parameter int SECT_OFF = 448
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   walkReq,
  input  logic [SEC_W+PG_W-1:0]  walkVpn,
  input  logic [PPN_W-1:0]       ptBase,
  input  logic [PPN_W+PG_W-1:0]  sptBase,
  input  logic                   cstEn,
  input  logic [PPN_W+PG_W-1:0]  cstBase,
  output logic                   walkBusy,
  output logic                   walkDone,
  output logic                   walkFault,
  output logic [PPN_W-1:0]       walkPpn,
  output logic [1:0]             faultCause,
  output logic                   memReq,
  output logic                   memWe,
  output logic [PPN_W+PG_W-1:0]  memAddr,
  output logic [WORD_W-1:0]      memWdata,
  input  logic                   memAck,
  input  logic [WORD_W-1:0]      memRdata
);
  walkStrobe_t strobe;
  logic [2:0]  ptrKind;
  logic        pageLevel;
  logic        hopLimit;

  walk_control u_ctrl (
    .clk(clk), .rstN(rstN), .walkReq(walkReq), .memAck(memAck), .cstEn(cstEn),
    .ptrKind(ptrKind), .pageLevel(pageLevel), .hopLimit(hopLimit),
    .strobe(strobe), .memReq(memReq), .memWe(memWe), .walkBusy(walkBusy),
    .walkDone(walkDone), .walkFault(walkFault), .faultCause(faultCause)
  );

  walk_datapath #(
    .WORD_W(WORD_W), .SEC_W(SEC_W), .PG_W(PG_W), .PPN_W(PPN_W),
    .MAX_HOPS(MAX_HOPS), .SECT_OFF(SECT_OFF)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .walkVpn(walkVpn), .ptBase(ptBase),
    .sptBase(sptBase), .cstBase(cstBase), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .ptrKind(ptrKind), .pageLevel(pageLevel),
    .hopLimit(hopLimit), .walkPpn(walkPpn)
  );

endmodule

// File: rtl/walk_checker.sv
module walk_checker #(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rstN,
  input logic              walkBusy,
  input logic              walkDone,
  input logic              walkFault,
  input logic [1:0]        faultCause,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic              cstEn
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !walkBusy |-> !memReq);

  p_fault_code_r6: assert property (@(posedge clk) disable iff (!rstN)
    walkFault |-> faultCause != 2'd0);

  p_status_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> cstEn);

  p_single_outcome_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(walkDone && walkFault));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    walkDone |=> !walkDone);

  p_fault_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    walkFault |=> !walkFault);

  p_outcome_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (walkDone || walkFault) |=> !walkBusy);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

endmodule

bind page_walker walk_checker #(.ADDR_W(PPN_W + PG_W)) u_chk (
  .clk(clk), .rstN(rstN), .walkBusy(walkBusy), .walkDone(walkDone),
  .walkFault(walkFault), .faultCause(faultCause), .memReq(memReq),
  .memWe(memWe), .memAck(memAck), .memAddr(memAddr), .cstEn(cstEn)
);

// File: tb/page_walker_test.sv
module page_walker_test;
  localparam logic [12:0] PT   = 13'h010;
  localparam logic [21:0] SPT  = 22'h003000;
  localparam logic [21:0] CST  = 22'h010000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        walkReq = 1'b0;
  logic [13:0] walkVpn = '0;
  logic        cstEn = 1'b0;
  logic        walkBusy, walkDone, walkFault, memReq, memWe;
  logic [12:0] walkPpn;
  logic [1:0]  faultCause;
  logic [21:0] memAddr;
  logic [35:0] memWdata;
  logic        memAck = 1'b0;
  logic [35:0] memRdata = '0;

  logic [35:0] mem [logic [21:0]];
  int          writeCnt = 0;
  int          checkCnt = 0;
  int          failCnt = 0;
  logic [15:0] expQ [$];
  string       tagQ [$];

  always #5 clk = ~clk;

  page_walker uut (
    .clk(clk), .rstN(rstN), .walkReq(walkReq), .walkVpn(walkVpn), .ptBase(PT),
    .sptBase(SPT), .cstEn(cstEn), .cstBase(CST), .walkBusy(walkBusy),
    .walkDone(walkDone), .walkFault(walkFault), .walkPpn(walkPpn),
    .faultCause(faultCause), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  function automatic logic [35:0] rd(input logic [21:0] a);
    return mem.exists(a) ? mem[a] : 36'h0;
  endfunction

  function automatic logic [21:0] pa(input logic [12:0] pg, input int w);
    return {pg, 9'(w)};
  endfunction

  function automatic logic [35:0] ptr(input logic [2:0] k, input logic [8:0] idx, input logic [17:0] low);
    return {k, 6'h00, idx, low};
  endfunction

  always @(posedge clk) begin
    memAck <= 1'b0;
    if (rstN && memReq && !memAck) begin
      memAck   <= 1'b1;
      memRdata <= rd(memAddr);
      if (memWe) begin
        mem[memAddr] = memWdata;
        writeCnt++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && (walkDone || walkFault)) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10 unexpected outcome", {walkDone, walkFault}, 0);
      end else begin
        logic [15:0] e;
        logic [15:0] a;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        a = {walkFault, (walkFault ? faultCause : 2'd0), (walkFault ? 13'h0 : walkPpn)};
        check(a == e && !(walkDone && walkFault), t, a, e);
      end
    end
  end

  task automatic runWalk(input logic [4:0] sec, input logic [8:0] pg, input bit f,
                         input logic [1:0] c, input logic [12:0] p, input string tag);
    expQ.push_back({f, c, (f ? 13'h0 : p)});
    tagQ.push_back(tag);
    writeCnt = 0;
    @(negedge clk);
    walkVpn = {sec, pg};
    walkReq = 1'b1;
    @(negedge clk);
    walkReq = 1'b0;
    while (!(walkDone || walkFault)) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL R10 watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    // table contents
    mem[pa(PT, 448 + 2)] = ptr(3'd1, 9'h1AB, 18'h3E020);
    mem[pa(13'h20, 5)]   = ptr(3'd1, 9'h0, 18'h00123) | 36'h1F8000000;
    mem[pa(PT, 448 + 3)] = ptr(3'd2, 9'h0, 18'd7);
    mem[SPT + 7]         = 36'hFFF000021;
    mem[pa(13'h21, 9)]   = ptr(3'd2, 9'h0, 18'd8);
    mem[SPT + 8]         = 36'h000000456;
    mem[pa(PT, 448 + 4)] = ptr(3'd3, 9'd10, 18'd9);
    mem[SPT + 9]         = 36'h30;
    mem[pa(13'h30, 10)]  = ptr(3'd1, 9'h0, 18'h22);
    mem[pa(13'h22, 1)]   = ptr(3'd3, 9'd20, 18'd11);
    mem[SPT + 11]        = 36'h23;
    mem[pa(13'h23, 20)]  = ptr(3'd1, 9'h0, 18'h777);
    mem[pa(PT, 448 + 6)] = ptr(3'd1, 9'h0, 18'h26);
    mem[pa(PT, 448 + 9)] = ptr(3'd5, 9'h0, 18'h0);
    mem[pa(PT, 448 + 10)] = ptr(3'd1, 9'h0, 18'h27);
    mem[pa(13'h27, 0)]   = ptr(3'd7, 9'h0, 18'h11);
    for (int k = 0; k < 8; k++) begin
      mem[pa(13'h50 + 13'(k), 0)] = ptr(3'd3, 9'd0, 18'(20 + k));
      mem[SPT + 22'(20 + k)]      = 36'(13'h51 + 13'(k));
    end
    mem[pa(PT, 448 + 7)] = ptr(3'd3, 9'd0, 18'd20);
    mem[pa(13'h58, 0)]   = ptr(3'd1, 9'h0, 18'h24);
    mem[pa(13'h24, 12)]  = ptr(3'd1, 9'h0, 18'h0AB);
    mem[pa(PT, 448 + 8)] = ptr(3'd3, 9'd0, 18'd19);
    mem[SPT + 19]        = 36'h50;
    mem[pa(PT, 448 + 31)] = ptr(3'd1, 9'h0, 18'h25);
    mem[pa(13'h25, 511)] = ptr(3'd1, 9'h0, 18'h3FFFF);
    mem[CST + 22'h20]    = 36'h0000000F0;
    mem[CST + 22'h123]   = 36'h800000000;
    mem[CST + 22'h21]    = 36'h000000055;
    mem[CST + 22'h456]   = 36'h000000054;
    mem[CST + 22'h26]    = 36'h000000032;

    repeat (3) @(negedge clk);
    check(!walkBusy && !walkDone && !walkFault && !memReq, "R1 reset idle",
          {walkBusy, walkDone, walkFault, memReq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!walkBusy && !memReq, "R1 idle after release", {walkBusy, memReq}, 0);

    runWalk(5'd2, 9'd5, 0, 2'd0, 13'h123, "R2 immediate both levels");
    runWalk(5'd31, 9'd511, 0, 2'd0, 13'h1FFF, "R2 last section and last index");
    runWalk(5'd3, 9'd9, 0, 2'd0, 13'h456, "R3 shared both levels");
    check(writeCnt == 0, "R9 no writes with status off", writeCnt, 0);
    check(rd(CST + 22'h21) == 36'h55, "R9 status word untouched", rd(CST + 22'h21), 36'h55);
    runWalk(5'd4, 9'd1, 0, 2'd0, 13'h777, "R4 indirect both levels");
    runWalk(5'd5, 9'd0, 1, 2'd1, 13'h0, "R5 invalid section entry");
    cstEn = 1'b1;
    runWalk(5'd6, 9'd3, 1, 2'd1, 13'h0, "R5 invalid page-map entry");
    check(writeCnt == 0, "R9 no writes on fault", writeCnt, 0);
    check(rd(CST + 22'h26) == 36'h32, "R9 map status untouched on fault", rd(CST + 22'h26), 36'h32);
    cstEn = 1'b0;
    runWalk(5'd9, 9'd0, 1, 2'd2, 13'h0, "R6 kind 5 at section level");
    runWalk(5'd10, 9'd0, 1, 2'd2, 13'h0, "R6 kind 7 at page level");
    runWalk(5'd7, 9'd12, 0, 2'd0, 13'h0AB, "R7 exactly eight hops");
    runWalk(5'd8, 9'd12, 1, 2'd3, 13'h0, "R7 ninth hop faults");
    cstEn = 1'b1;
    runWalk(5'd2, 9'd5, 0, 2'd0, 13'h123, "R8 walk with status on");
    check(writeCnt == 2, "R8 two status writes", writeCnt, 2);
    check(rd(CST + 22'h20) == 36'h0F1, "R8 map page marked", rd(CST + 22'h20), 36'h0F1);
    check(rd(CST + 22'h123) == 36'h800000001, "R8 final page marked", rd(CST + 22'h123), 36'h800000001);
    cstEn = 1'b0;
    repeat (4) @(negedge clk);
    check(expQ.size() == 0 && !walkBusy, "R10 every request answered once", expQ.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule